// File: doc/BRIEF.md
# Configuration Write Lock Gatekeeper

This block guards the configuration space of an access-control unit. Every register write presented on a simple write bus (strobe, address, data, writer domain) is judged against a two-bit lock held in the control register. The verdict is given combinationally on `wr_ok_o` in the same cycle, so the descriptor storage around the block can use it as its write enable. A write that is refused changes nothing and raises `wr_err_o` for one cycle.

The lock has four states: open, open and pinned open until reset, owner-only, and frozen until reset. When the lock moves from open to owner-only, the domain of the writer that did so becomes the owner. From that point only the owner may write, and the lock itself stays where it is until reset. The control register also drives two global enables: one for master-to-domain assignment and one for access enforcement. When access enforcement is clear, the downstream checker lets every transaction through.

A read-only status word reports three things: the domain currently on the bus, a fixed hardware revision, and the lock owner.

Top module: `cfg_wlock`

## Requirements
- R1: After reset the lock is open (code 00), both enables are 0, the owner is 0, `ctrl_o` is 0 and `wr_err_o` is 0.
- R2: With lock code 00 or 01, `wr_ok_o` equals `wr_en_i` for every writer domain and every address.
- R3: With lock code 10, `wr_ok_o` is high only when `wr_en_i` is high and `wr_dom_i` equals the owner.
- R4: With lock code 11, `wr_ok_o` is always 0.
- R5: A refused write (`wr_en_i` high, `wr_ok_o` low) leaves `ctrl_o` and the owner unchanged. It drives `wr_err_o` high in the next cycle only.
- R6: A permitted control write that moves the lock from 00 to 10 records `wr_dom_i` as the owner, visible at `stat_o[11:8]` from the next cycle.
- R7: While the lock is 01, the lock field of any control write is ignored and stays 01 until reset. The enable bits are still written.
- R8: While the lock is 10 or 11, the lock field and the owner cannot change until reset. In state 10 the owner can still write the enable bits.
- R9: `ctrl_o` bit 0 is the domain-assignment enable (`mda_en_o`), bit 1 is the access enforcement enable (`acc_en_o`), and bits 5:4 are the lock code. All other bits read 0. A permitted write at `CTRL_ADDR` loads bits 1:0 and, subject to R7/R8, bits 5:4.
- R10: `stat_o` bits 3:0 are `wr_dom_i`, bits 7:4 are `HW_REV` and bits 11:8 are the owner. All other bits are 0. A write to `STAT_ADDR` changes no state.
- R11: A permitted write to any address other than `CTRL_ADDR` asserts `wr_ok_o` but leaves `ctrl_o` and the owner unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| wr_dom_i | input | DOM_W | Domain ID of the writer |
| wr_ok_o | output | 1 | Write permitted this cycle |
| wr_err_o | output | 1 | One-cycle pulse after a refused write |
| mda_en_o | output | 1 | Global master domain assignment enable |
| acc_en_o | output | 1 | Global access enforcement enable |
| ctrl_o | output | DATA_W | Control register contents |
| stat_o | output | DATA_W | Status register contents |

## Verification
The bench builds the block with an 8-bit address, the control register at 0x00, the status register at 0x04 and a revision of 0xA. The nonzero revision makes a miswired status field visible. The 4-bit domain width brings all sixteen writer domains within reach, so the owner-only and frozen states are tried against every domain, not just the owner. Resets between phases let each of the three lock transitions out of the open state be driven from a clean start.

// File: rtl/cfg_wlock_pkg.sv
package cfg_wlock_pkg;
  typedef enum logic [1:0] {
    LK_OPEN      = 2'b00,
    LK_OPEN_HELD = 2'b01,
    LK_OWNER     = 2'b10,
    LK_FROZEN    = 2'b11
  } lock_e;

  localparam int unsigned MDA_BIT  = 0;
  localparam int unsigned ACC_BIT  = 1;
  localparam int unsigned LOCK_LSB = 4;
  localparam int unsigned REV_LSB  = 4;
  localparam int unsigned REV_W    = 4;
  localparam int unsigned OWN_LSB  = 8;
endpackage

// File: rtl/cfg_wlock_perm.sv
module cfg_wlock_perm
  import cfg_wlock_pkg::*;
#(
  parameter int unsigned DOM_W = 4
) (
  input  logic             wr_en_i,
  input  lock_e            lock_i,
  input  logic [DOM_W-1:0] owner_i,
  input  logic [DOM_W-1:0] dom_i,
  output logic             ok_o,
  output logic             blocked_o
);
  logic allow;

  always_comb begin
    unique case (lock_i)
      LK_OPEN, LK_OPEN_HELD: allow = 1'b1;
      LK_OWNER:              allow = (dom_i == owner_i);
      default:               allow = 1'b0;
    endcase
  end

  assign ok_o      = wr_en_i & allow;
  assign blocked_o = wr_en_i & ~allow;
endmodule

// File: rtl/cfg_wlock_regs.sv
module cfg_wlock_regs
  import cfg_wlock_pkg::*;
#(
  parameter int unsigned DOM_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       en_d_i,
  input  logic [1:0]       lock_d_i,
  input  logic [DOM_W-1:0] dom_i,
  output lock_e            lock_o,
  output logic [1:0]       en_o,
  output logic [DOM_W-1:0] owner_o
);
  lock_e            lock_q, lock_d;
  logic [1:0]       en_q;
  logic [DOM_W-1:0] owner_q, owner_d;

  // lock field is only writable from the open state
  always_comb begin
    lock_d  = lock_q;
    owner_d = owner_q;
    if (we_i && lock_q == LK_OPEN) begin
      lock_d = lock_e'(lock_d_i);
      if (lock_e'(lock_d_i) == LK_OWNER) owner_d = dom_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= LK_OPEN;
      en_q    <= '0;
      owner_q <= '0;
    end else begin
      lock_q  <= lock_d;
      owner_q <= owner_d;
      if (we_i) en_q <= en_d_i;
    end
  end

  assign lock_o  = lock_q;
  assign en_o    = en_q;
  assign owner_o = owner_q;

  // R7
  open_held_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q == LK_OPEN_HELD |=> lock_q == LK_OPEN_HELD);
  // R8
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q[1] |=> $stable(lock_q) && $stable(owner_q));
endmodule

// File: rtl/cfg_wlock_err.sv
module cfg_wlock_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic blocked_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= blocked_i;
  end

  assign err_o = err_q;
endmodule

// File: rtl/cfg_wlock.sv
module cfg_wlock
  import cfg_wlock_pkg::*;
#(
  parameter int unsigned DOM_W     = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h04,
  parameter logic [REV_W-1:0]  HW_REV    = 4'h1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DOM_W-1:0]  wr_dom_i,
  output logic              wr_ok_o,
  output logic              wr_err_o,
  output logic              mda_en_o,
  output logic              acc_en_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] stat_o
);
  localparam int unsigned STAT_USED = OWN_LSB + DOM_W;

  lock_e            lock;
  logic [1:0]       en;
  logic [DOM_W-1:0] owner;
  logic             blocked, ctrl_we;
  logic             unused_data;

  assign unused_data = ^{wr_data_i[DATA_W-1:LOCK_LSB+2], wr_data_i[LOCK_LSB-1:2]};

  cfg_wlock_perm #(.DOM_W(DOM_W)) u_perm (
    .wr_en_i  (wr_en_i),
    .lock_i   (lock),
    .owner_i  (owner),
    .dom_i    (wr_dom_i),
    .ok_o     (wr_ok_o),
    .blocked_o(blocked)
  );

  // status address never reaches state
  assign ctrl_we = wr_ok_o && (wr_addr_i == CTRL_ADDR) && (CTRL_ADDR != STAT_ADDR);

  cfg_wlock_regs #(.DOM_W(DOM_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we),
    .en_d_i  (wr_data_i[1:0]),
    .lock_d_i(wr_data_i[LOCK_LSB+:2]),
    .dom_i   (wr_dom_i),
    .lock_o  (lock),
    .en_o    (en),
    .owner_o (owner)
  );

  cfg_wlock_err u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .blocked_i(blocked),
    .err_o    (wr_err_o)
  );

  assign mda_en_o = en[MDA_BIT];
  assign acc_en_o = en[ACC_BIT];

  always_comb begin
    ctrl_o                   = '0;
    ctrl_o[MDA_BIT]          = en[MDA_BIT];
    ctrl_o[ACC_BIT]          = en[ACC_BIT];
    ctrl_o[LOCK_LSB+:2]      = lock;
    stat_o                   = '0;
    stat_o[DOM_W-1:0]        = wr_dom_i;
    stat_o[REV_LSB+:REV_W]   = HW_REV;
    stat_o[OWN_LSB+:DOM_W]   = owner;
  end

  initial begin
    assert (DATA_W >= STAT_USED && DOM_W <= 4) else $error("cfg_wlock: bad widths");
  end

  // R4
  frozen_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock == LK_FROZEN |-> !wr_ok_o);
  // R3
  owner_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock == LK_OWNER && wr_ok_o) |-> wr_dom_i == stat_o[OWN_LSB+:DOM_W]);
  // R5
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_ok_o) |=> wr_err_o && $stable(ctrl_o));
  // R5
  no_spurious_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && !wr_ok_o) |=> !wr_err_o);
  // R2
  open_allows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock[1] |-> wr_ok_o == wr_en_i);
endmodule

// File: tb/cfg_wlock_bench.sv
module cfg_wlock_bench;
  localparam logic [7:0] CA  = 8'h00;
  localparam logic [7:0] SA  = 8'h04;
  localparam logic [3:0] REV = 4'hA;

  logic        clk = 0, rst_ni = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [3:0]  wr_dom = 0;
  logic        wr_ok, wr_err, mda_en, acc_en;
  logic [31:0] ctrl, stat;

  always #5 clk = ~clk;

  cfg_wlock #(.DOM_W(4), .DATA_W(32), .ADDR_W(8), .CTRL_ADDR(CA), .STAT_ADDR(SA),
              .HW_REV(REV)) u_cfg_wlock (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_dom_i(wr_dom), .wr_ok_o(wr_ok), .wr_err_o(wr_err),
    .mda_en_o(mda_en), .acc_en_o(acc_en), .ctrl_o(ctrl), .stat_o(stat));

  int    n_vec = 0, n_bad = 0;
  bit    done = 0;
  string req = "R1";
  int    m_lock, m_owner, m_en, m_err;

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    int perm;
    perm = (m_lock < 2) || (m_lock == 2 && int'(wr_dom) == m_owner);
    cmp("wr_ok", 32'(wr_ok), 32'(wr_en && perm));
    cmp("wr_err", 32'(wr_err), 32'(m_err));
    cmp("mda_en", 32'(mda_en), 32'(m_en & 1));
    cmp("acc_en", 32'(acc_en), 32'((m_en >> 1) & 1));
    cmp("ctrl", ctrl, 32'((m_lock << 4) | m_en));
    cmp("stat", stat, 32'((m_owner << 8) | (int'(REV) << 4) | int'(wr_dom)));
  endtask

  task automatic model_reset();
    m_lock = 0; m_owner = 0; m_en = 0; m_err = 0;
  endtask

  // one bus cycle: drive, check against model, advance model
  task automatic cyc(bit en, logic [7:0] a, logic [31:0] d, logic [3:0] dom);
    int perm, n_lock, n_owner, n_en;
    wr_en = en; wr_addr = a; wr_data = d; wr_dom = dom;
    #1;
    check_all();
    perm = (m_lock < 2) || (m_lock == 2 && int'(dom) == m_owner);
    n_lock = m_lock; n_owner = m_owner; n_en = m_en;
    if (en && perm && a == CA) begin
      n_en = int'(d[1:0]);
      if (m_lock == 0) begin
        n_lock = int'(d[5:4]);
        if (n_lock == 2) n_owner = int'(dom);
      end
    end
    @(posedge clk);
    @(negedge clk);
    m_err = en && !perm;
    m_lock = n_lock; m_owner = n_owner; m_en = n_en;
  endtask

  task automatic do_reset();
    wr_en = 0;
    rst_ni = 0;
    @(posedge clk); @(negedge clk);
    model_reset();
    rst_ni = 1;
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    req = "R1"; cyc(0, CA, 0, 4'h0);
    // R9 enables
    req = "R9"; cyc(1, CA, 32'hFFFF_FFC3, 4'h3); cyc(0, CA, 0, 4'h3);
    cyc(1, CA, 32'h0000_0002, 4'h9); cyc(1, CA, 32'h0000_0001, 4'h9);
    // R11 other addresses
    req = "R11"; cyc(1, 8'h10, 32'hFFFF_FFFF, 4'h7); cyc(1, 8'h08, 32'h0000_0032, 4'h1);
    // R10 status write ignored
    req = "R10"; cyc(1, SA, 32'hFFFF_FFFF, 4'hF); cyc(0, SA, 0, 4'h5);
    // R2 open: every domain allowed
    req = "R2";
    for (int i = 0; i < 16; i++) cyc(1, 8'(i * 3), 32'(i * 32'h1111_0000), 4'(i));
    // R7 pin open
    req = "R7"; cyc(1, CA, 32'h0000_0010, 4'h5);
    cyc(1, CA, 32'h0000_0023, 4'h5); cyc(1, CA, 32'h0000_0031, 4'hC);
    req = "R2"; for (int i = 0; i < 16; i++) cyc(1, CA, 32'h10 | 32'(i & 3), 4'(i));
    do_reset();
    // R6 owner capture
    req = "R6"; cyc(1, CA, 32'h0000_0021, 4'h6); cyc(0, CA, 0, 4'h6);
    // R3/R5 other domains refused
    req = "R3";
    for (int i = 0; i < 16; i++) cyc(1, CA, 32'h0000_0033, 4'(i));
    req = "R5"; cyc(1, CA, 32'h0000_0002, 4'h2); cyc(0, CA, 0, 4'h2);
    cyc(1, 8'h20, 32'h0, 4'h2); cyc(1, 8'h20, 32'h0, 4'h6);
    // R8 owner edits enables, lock fixed
    req = "R8"; cyc(1, CA, 32'h0000_0032, 4'h6); cyc(1, CA, 32'h0000_0003, 4'h6);
    cyc(1, CA, 32'h0000_0000, 4'h6); cyc(0, CA, 0, 4'h0);
    do_reset();
    // R4 freeze
    req = "R4"; cyc(1, CA, 32'h0000_0033, 4'h1);
    for (int i = 0; i < 16; i++) cyc(1, 8'(i), 32'h0000_0000, 4'(i));
    req = "R5"; cyc(0, CA, 0, 4'h1); cyc(1, CA, 32'h0, 4'h1); cyc(0, CA, 0, 4'h1);
    req = "R1"; do_reset(); cyc(0, CA, 0, 4'h4);
    // R6 capture from a second domain; frozen-from-open keeps owner 0 path covered above
    req = "R6"; cyc(1, CA, 32'h0000_0020, 4'hE); cyc(1, CA, 32'h0000_0001, 4'hE);
    cyc(1, CA, 32'h0000_0001, 4'h0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule